// File: doc/BRIEF.md
# Container Element Reversal Unit

This unit executes one vector permutation for a wide-datapath execution pipe. It takes a 32-bit instruction word and a source operand of up to 128 bits. From fields of the word it finds three things: the size of a container (64, 32, 16 or 8 bits), the size of an element (8, 16, 32 or 64 bits) and whether the operation covers 64 or 128 bits. Within every container it then reverses the order of the elements. The bits inside each element keep their order. Every container is handled on its own.

An element that is not smaller than its container makes the word undefined. The unit then reports it and writes nothing. A single enable input says whether vector execution is allowed. When it is low, the unit raises a trap instead, and the trap wins over the undefined check. Results come back one cycle after the input, together with the destination register index and the status flags. The destination register file sits outside the unit.

Because every element and container size is a power of two, reversing the elements within a container comes down to an exclusive-or on the byte lane index. One byte-lane crossbar with a 3-bit lane mask therefore covers every legal size pairing.

Top module: `rev_unit`

## Requirements
- R1: The container code is the two bits {insn[12], insn[29]}. Code 0 selects a 64-bit container, 1 selects 32 bits, 2 selects 16 bits and 3 selects 8 bits.
- R2: The element size is 8 << insn[23:22]: 8, 16, 32 or 64 bits.
- R3: When the container is not larger than the element, out_undef is 1 with out_valid, out_wr_en is 0 and out_result is zero.
- R4: insn[30] selects the width. With 0 only the low 64 bits are processed and out_result[127:64] is zero. With 1 all 128 bits are processed.
- R5: For a legal word, element k of each container lands at position (n-1-k), where n is the number of elements per container. Bits inside an element are unchanged, and no data crosses a container boundary.
- R6: out_dst carries insn[4:0]. The source index insn[9:5] is decoded and has no effect on out_result.
- R7: When in_en is 0 with in_valid, out_trap is 1, out_undef is 0, out_wr_en is 0 and out_result is zero, whatever the size fields hold.
- R8: An accepted input produces out_valid exactly one clock later, so back-to-back inputs give back-to-back outputs. Without in_valid, out_valid, out_wr_en, out_undef and out_trap are all 0 on the next cycle.
- R9: A synchronous active-high rst clears out_valid, every flag and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand present this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector |
| in_en | input | 1 | Vector execution permitted |
| out_valid | output | 1 | Result slot valid |
| out_wr_en | output | 1 | Result to be written to destination |
| out_dst | output | 5 | Destination register index |
| out_result | output | 128 | Permuted vector |
| out_undef | output | 1 | Size combination undefined |
| out_trap | output | 1 | Execution not permitted |

## Verification
The bench steps through all 32 combinations of width, element size and container code, with and without enable and with random data. The reference model moves data element by element in loops, so a wrong lane mask shows up as bytes swapped across an element or across a container boundary. Pairings where the element equals the container must raise undefined. A decoder off by one in its comparison would instead write an unchanged vector there. A unit that ignores the width bit would leak data into the upper half on 64-bit operations. If the unit checked legality before enable, a disabled word with illegal sizes would report undefined instead of trap.

// File: rtl/rev_unit_pkg.sv
package rev_unit_pkg;

  localparam int INSN_W      = 32;
  localparam int REG_IDX_W   = 5;
  localparam int MASK_W      = 3;

  localparam int POS_DST_LO  = 0;
  localparam int POS_SRC_LO  = 5;
  localparam int POS_CHI     = 12;
  localparam int POS_ESZ_LO  = 22;
  localparam int POS_CLO     = 29;
  localparam int POS_WIDE    = 30;

  typedef struct packed {
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src;
    logic [1:0]           cont_code;
    logic [1:0]           elem_code;
    logic                 wide;
  } rev_fields_t;

  // log2 of container size in bits: 64 >> code
  function automatic logic [2:0] cont_log2(input logic [1:0] code);
    return 3'd6 - {1'b0, code};
  endfunction

  // log2 of element size in bits: 8 << code
  function automatic logic [2:0] elem_log2(input logic [1:0] code);
    return 3'd3 + {1'b0, code};
  endfunction

  function automatic logic is_undef(input logic [1:0] cc, input logic [1:0] ec);
    return cont_log2(cc) <= elem_log2(ec);
  endfunction

  // Byte-lane xor mask: (container_bytes-1) & ~(element_bytes-1)
  function automatic logic [MASK_W-1:0] lane_mask(input logic [1:0] cc,
                                                   input logic [1:0] ec);
    logic [MASK_W:0] cbytes;
    logic [MASK_W:0] ebytes;
    logic [MASK_W:0] m;
    cbytes = (MASK_W+1)'(8) >> cc;
    ebytes = (MASK_W+1)'(1) << ec;
    m      = (cbytes - (MASK_W+1)'(1)) & ~(ebytes - (MASK_W+1)'(1));
    return m[MASK_W-1:0];
  endfunction

endpackage

// File: rtl/rev_field_decode.sv
module rev_field_decode
  import rev_unit_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output rev_fields_t       fields,
  output logic              undef,
  output logic [MASK_W-1:0] mask
);

  always_comb begin
    fields.dst       = insn[POS_DST_LO +: REG_IDX_W];
    fields.src       = insn[POS_SRC_LO +: REG_IDX_W];
    fields.cont_code = {insn[POS_CHI], insn[POS_CLO]};
    fields.elem_code = insn[POS_ESZ_LO +: 2];
    fields.wide      = insn[POS_WIDE];
  end

  assign undef = is_undef(fields.cont_code, fields.elem_code);
  assign mask  = lane_mask(fields.cont_code, fields.elem_code);

endmodule

// File: rtl/rev_lane_permute.sv
module rev_lane_permute
  import rev_unit_pkg::*;
#(
  parameter int DATA_W = 128
)(
  input  logic [DATA_W-1:0] data_in,
  input  logic [MASK_W-1:0] mask,
  input  logic              wide,
  output logic [DATA_W-1:0] data_out
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int HALF   = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] src_lane;
    logic              keep;
    assign src_lane = LANE_W'(i) ^ LANE_W'(mask);
    assign keep     = wide || (i < HALF);
    always_comb begin
      data_out[i*8 +: 8] = keep ? data_in[src_lane*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/rev_unit.sv
module rev_unit
  import rev_unit_pkg::*;
#(
  parameter int DATA_W = 128
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [DATA_W-1:0]    in_src,
  input  logic                 in_en,
  output logic                 out_valid,
  output logic                 out_wr_en,
  output logic [REG_IDX_W-1:0] out_dst,
  output logic [DATA_W-1:0]    out_result,
  output logic                 out_undef,
  output logic                 out_trap
);

  rev_fields_t       dec_fields;
  logic              dec_undef;
  logic [MASK_W-1:0] dec_mask;
  logic [DATA_W-1:0] perm_data;

  // Named events for the checker
  logic ev_trap;
  logic ev_undef;
  logic ev_write;

  rev_field_decode u_dec (
    .insn   (in_insn),
    .fields (dec_fields),
    .undef  (dec_undef),
    .mask   (dec_mask)
  );

  rev_lane_permute #(.DATA_W(DATA_W)) u_perm (
    .data_in  (in_src),
    .mask     (dec_mask),
    .wide     (dec_fields.wide),
    .data_out (perm_data)
  );

  assign ev_trap  = in_valid && !in_en;
  assign ev_undef = in_valid && in_en && dec_undef;
  assign ev_write = in_valid && in_en && !dec_undef;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_undef  <= 1'b0;
      out_trap   <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
    end else begin
      out_valid  <= in_valid;
      out_wr_en  <= ev_write;
      out_undef  <= ev_undef;
      out_trap   <= ev_trap;
      out_dst    <= in_valid ? dec_fields.dst : out_dst;
      out_result <= ev_write ? perm_data : '0;
    end
  end

endmodule

// File: rtl/rev_unit_chk.sv
module rev_unit_chk
  import rev_unit_pkg::*;
#(
  parameter int DATA_W = 128
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [INSN_W-1:0]    in_insn,
  input logic                 in_en,
  input logic                 dec_undef,
  input logic                 out_valid,
  input logic                 out_wr_en,
  input logic [REG_IDX_W-1:0] out_dst,
  input logic [DATA_W-1:0]    out_result,
  input logic                 out_undef,
  input logic                 out_trap
);

  localparam int HALF = DATA_W / 2;

  assert_undef_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (!out_wr_en && out_result == '0));

  assert_decoded_undef_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_en && dec_undef) |=> out_undef);

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_insn[POS_WIDE]) |=> (out_result[DATA_W-1:HALF] == '0));

  assert_dst_index_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_dst == $past(in_insn[POS_DST_LO +: REG_IDX_W])));

  assert_trap_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_en) |=> (out_trap && !out_undef && !out_wr_en));

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_wr_en || out_undef || out_trap));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_wr_en, out_undef, out_trap}) == 1);

endmodule

bind rev_unit rev_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .in_en      (in_en),
  .dec_undef  (dec_undef),
  .out_valid  (out_valid),
  .out_wr_en  (out_wr_en),
  .out_dst    (out_dst),
  .out_result (out_result),
  .out_undef  (out_undef),
  .out_trap   (out_trap)
);

// File: tb/rev_unit_tb.sv
module rev_unit_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  in_insn;
  logic [127:0] in_src;
  logic         in_en;
  logic         out_valid, out_wr_en, out_undef, out_trap;
  logic [4:0]   out_dst;
  logic [127:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // expected outputs for the next sample
  bit           e_valid, e_wr, e_undef, e_trap;
  logic [4:0]   e_dst;
  logic [127:0] e_res;

  always #5 clk = ~clk;

  rev_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .in_en(in_en), .out_valid(out_valid),
    .out_wr_en(out_wr_en), .out_dst(out_dst), .out_result(out_result),
    .out_undef(out_undef), .out_trap(out_trap)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: element loops over each container
  function automatic logic [127:0] model(input logic [127:0] src, input int wide,
                                         input int esz_code, input int ccode);
    logic [127:0] r = '0;
    int dw = 64 << wide;
    int cs = 64 >> ccode;
    int es = 8 << esz_code;
    int n  = cs / es;
    for (int c = 0; c < dw / cs; c++)
      for (int k = 0; k < n; k++)
        for (int b = 0; b < es; b++)
          r[c*cs + (n-1-k)*es + b] = src[c*cs + k*es + b];
    return r;
  endfunction

  task automatic compare_now();
    chk("R8 out_valid", 128'(out_valid), 128'(e_valid));
    if (e_valid) begin
      chk("R3/R5 out_wr_en", 128'(out_wr_en), 128'(e_wr));
      chk("R3 out_undef",    128'(out_undef), 128'(e_undef));
      chk("R7 out_trap",     128'(out_trap),  128'(e_trap));
      chk("R6 out_dst",      128'(out_dst),   128'(e_dst));
      chk("R4/R5 out_result", out_result, e_res);
    end else begin
      chk("R8 idle flags", 128'({out_wr_en, out_undef, out_trap}), 128'(0));
    end
  endtask

  task automatic issue(input bit v, input int wide, input int esz, input int cc,
                       input bit en, input logic [127:0] src);
    logic [31:0] w;
    w = $urandom();
    w[30] = wide[0];
    w[23:22] = esz[1:0];
    w[12] = cc[1];
    w[29] = cc[0];
    @(negedge clk);
    compare_now();
    in_valid = v; in_insn = w; in_src = src; in_en = en;
    e_valid = v;
    e_dst   = w[4:0];
    e_trap  = v && !en;
    // R1/R2: container 64>>cc must exceed element 8<<esz
    e_undef = v && en && ((64 >> cc) <= (8 << esz));
    e_wr    = v && en && !e_undef;
    e_res   = e_wr ? model(src, wide, esz, cc) : '0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_insn = '0; in_src = '0; in_en = 0;
    e_valid = 0; e_wr = 0; e_undef = 0; e_trap = 0; e_dst = '0; e_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", 128'(out_valid), 128'(0));
    chk("R9 flags", 128'({out_wr_en, out_undef, out_trap}), 128'(0));
    chk("R9 out_result", out_result, 128'(0));
    rst = 1'b0;
    // full sweep, back to back, with enable and random data
    for (int rep = 0; rep < 6; rep++)
      for (int q = 0; q < 2; q++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 4; c++)
            for (int en = 0; en < 2; en++) begin
              logic [127:0] d;
              d = {$urandom(), $urandom(), $urandom(), $urandom()};
              if (rep == 0) d = 128'h0f0e0d0c0b0a09080706050403020100;
              if (rep == 1) d = '1;
              issue(1'b1, q, s, c, en[0], d);
              if ((rep + s) % 3 == 0) issue(1'b0, q, s, c, 1'b1, d);
            end
    // R6: source index field is irrelevant; R5 spot check of 32-bit container, byte elements
    issue(1'b1, 1, 0, 1, 1'b1, 128'h0f0e0d0c0b0a09080706050403020100);
    @(negedge clk);
    compare_now();
    chk("R5 known pattern", out_result, 128'h0c0d0e0f08090a0b0405060700010203);
    in_valid = 0; e_valid = 0;
    @(negedge clk);
    compare_now();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule